// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 64-bit virtual address into a physical page address. Each request carries an access need (any mix of read, write and execute) and a privilege mode. Addresses in the kernel superpage window are translated directly, with no memory traffic. Every other properly formed address is resolved by walking a three-level table of 64-bit entries, which are fetched one at a time through a single read port. The page size is 8 KB.

A request is accepted while `req_ready` is high. The result is a fault code, the physical page address and the permission set that the final entry grants. All three are presented with a one-cycle `done` strobe and stay unchanged until the next result. The level-1 table address is taken from the `ptbr` input at the moment the request is accepted.

The bit encodings are the same everywhere. Permission and need vectors use bit 0 for read, bit 1 for write and bit 2 for execute. Mode 0 is kernel. Fault codes are 0 for none, 1 for entry not valid, 2 for access violation, 3 for fault-on-read, 4 for fault-on-write and 5 for fault-on-execute.

Top module: `vaw_top`

## Requirements
- R1: If bits [63:43] of the virtual address are not all equal, the request completes with fault 2, makes no memory read, and raises `done` one cycle after acceptance.
- R2: A superpage address has bit 63 set, bits [42:41] equal to binary 10 and passes R1. A superpage address in a mode other than 0 completes with fault 2 and no memory read. An address with bits [42:41] equal to binary 10 but bit 63 clear is walked like any other address.
- R3: A superpage address in mode 0 completes one cycle after acceptance with fault 0 and permission 3'b111. The physical page holds virtual bits [39:13] in place and virtual bit 40 at physical bit 43; all other bits are zero.
- R4: The walk reads level 1, then level 2, then level 3. Each read address is the table address plus 8 times a 10-bit index. The indices are virtual bits [42:33], [32:23] and [22:13]. The level-1 table address is `ptbr`. Each later table address is entry bits [63:32] shifted left by 13.
- R5: An entry at any level with bit 0 clear ends the walk with fault 1.
- R6: A level-1 or level-2 entry that has bit 0 set but bit 8 clear ends the walk with fault 2.
- R7: In the level-3 entry, bit (8+mode) grants read and execute, and bit (12+mode) grants write. If the need is nonzero and shares no bit with the granted set, the result is fault 2.
- R8: Level-3 entry bits 1, 2 and 3 remove read, write and execute respectively from the granted set. The reported permission is the set left after this removal.
- R9: If the need is nonzero and none of its bits survive R8, the fault is 5 when the need includes execute, otherwise 4 when it includes write, otherwise 3.
- R10: At most one memory read is outstanding. `mem_req_valid` and `mem_req_addr` hold until `mem_req_ready` is seen. Each accepted read is answered by exactly one `mem_rsp_valid` beat. No read is issued while `req_ready` is high.
- R11: `done` is a single-cycle strobe. Between strobes, `fault`, `pa_page` and `perm` do not change. On any fault, `pa_page` and `perm` are zero. On success, bits [12:0] of `pa_page` are zero. After reset, `done` is 0, all results are zero and `req_ready` is 1.
- R12: A request with a need of zero never faults at level 3 once the three entries are valid and the level-1 and level-2 entries have bit 8 set. It returns the page and the permission left after R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle; request accepted this cycle if valid |
| req_va | input | 64 | Virtual address |
| req_mode | input | 2 | Privilege mode, 0 is kernel |
| req_need | input | 3 | Needed access: bit0 read, bit1 write, bit2 execute |
| ptbr | input | 64 | Physical address of the level-1 table |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 64 | Entry byte address |
| mem_rsp_valid | input | 1 | One-beat read response |
| mem_rsp_data | input | 64 | Entry contents |
| done | output | 1 | Result strobe |
| fault | output | 3 | Fault code |
| pa_page | output | 64 | Physical page address |
| perm | output | 3 | Granted permission set |

## Verification
The assertions assume that memory sends a response only after it has accepted a read, sends exactly one beat, and sends it while the walker is waiting. They also assume that `ptbr` is stable when a request is accepted. The bench memory keeps to these rules. It records the address at the cycle it raises ready against a pending request, and it returns a single beat after 0 to 2 idle cycles. The ready pattern and the latency vary from read to read, so every level sees stalls. Requests are driven only while `req_ready` is high, and the tables are fixed before the first request.

// File: rtl/vaw_pkg.sv
// Shared definitions for the virtual address walker.
// Assumes 64-bit table entries; the field positions below are behavioural.
package vaw_pkg;
    localparam int PTE_VALID_BIT = 0;
    localparam int PTE_FO_BASE   = 1;   // fault-on read/write/exec at 1,2,3
    localparam int PTE_RD_BASE   = 8;   // read enable for mode 0, shifted by mode
    localparam int PTE_WR_BASE   = 12;  // write enable for mode 0, shifted by mode
    localparam int PTE_PFN_LSB   = 32;

    localparam int ACC_RD = 0;
    localparam int ACC_WR = 1;
    localparam int ACC_EX = 2;

    typedef enum logic [2:0] {
        FLT_NONE     = 3'd0,
        FLT_INVALID  = 3'd1,
        FLT_ACCESS   = 3'd2,
        FLT_ON_READ  = 3'd3,
        FLT_ON_WRITE = 3'd4,
        FLT_ON_EXEC  = 3'd5
    } vaw_fault_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } vaw_state_e;
endpackage

// File: rtl/vaw_classify.sv
// Address classifier: checks sign extension above the implemented virtual
// bits, detects the direct-mapped superpage window, and forms its page.
// Assumes VA_BITS > SEG_LSB + 2 and SUPER_RELOC_BIT < 64.
module vaw_classify #(
    parameter int VA_BITS         = 44,
    parameter int PAGE_BITS       = 13,
    parameter int SEG_LSB         = 41,
    parameter int SUPER_PA_BITS   = 40,
    parameter int SUPER_RELOC_BIT = 43
) (
    input  logic [63:0] va,
    output logic        addr_ok,
    output logic        is_super,
    output logic [63:0] super_pa
);
    localparam int TOP_W = 64 - VA_BITS + 1;

    logic [TOP_W-1:0] top_bits;

    // Upper bits must all copy the highest implemented bit.
    always_comb begin
        top_bits = va[63:VA_BITS-1];
        addr_ok  = (&top_bits) | ~(|top_bits);
    end

    // Superpage window: negative address with segment code binary 10.
    always_comb begin
        is_super = va[63] && (va[SEG_LSB+1:SEG_LSB] == 2'b10);
    end

    // Direct map: low bits kept, one bit relocated, offset cleared.
    always_comb begin
        super_pa                         = '0;
        super_pa[SUPER_PA_BITS-1:0]      = va[SUPER_PA_BITS-1:0];
        super_pa[SUPER_RELOC_BIT]        = va[SUPER_PA_BITS];
        super_pa[PAGE_BITS-1:0]          = '0;
    end
endmodule

// File: rtl/vaw_index_sel.sv
// Selects the table index for the current walk level and forms the
// byte address of the entry. Level 0 uses the most significant field.
module vaw_index_sel #(
    parameter int PAGE_BITS = 13,
    parameter int IDX_BITS  = 10,
    parameter int LEVELS    = 3,
    parameter int LVL_W     = 2
) (
    input  logic [63:0]      va,
    input  logic [LVL_W-1:0] lvl,
    input  logic [63:0]      tbase,
    output logic [63:0]      entry_addr
);
    localparam int ENTRY_LOG = 3;

    logic [IDX_BITS-1:0] idx_lv [LEVELS];
    logic [IDX_BITS-1:0] idx_sel;

    generate
        for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
            localparam int LSB = PAGE_BITS + IDX_BITS * (LEVELS - 1 - g);
            assign idx_lv[g] = va[LSB +: IDX_BITS];
        end
    endgenerate

    // Pick the field of the active level and scale by the entry size.
    always_comb begin
        idx_sel = '0;
        for (int l = 0; l < LEVELS; l++) begin
            if (lvl == LVL_W'(l)) idx_sel = idx_lv[l];
        end
        entry_addr = tbase + (64'(idx_sel) << ENTRY_LOG);
    end
endmodule

// File: rtl/vaw_leaf_perm.sv
// Evaluates the final-level entry: grants by mode-shifted enable bits,
// removes rights through the fault-on bits, and picks the fault code.
// Assumes MODE_BITS small enough that both enable groups fit in bits 8..15.
module vaw_leaf_perm
    import vaw_pkg::*;
#(
    parameter int MODE_BITS = 2
) (
    input  logic [63:0]          pte,
    input  logic [MODE_BITS-1:0] mode,
    input  logic [2:0]           need,
    output logic [2:0]           perm,
    output vaw_fault_e           fault
);
    logic [5:0] rd_pos;
    logic [5:0] wr_pos;
    logic [2:0] grant;
    logic [2:0] keep;

    // Granted set from the enable bits of the requesting mode.
    always_comb begin
        rd_pos = 6'(PTE_RD_BASE) + 6'(mode);
        wr_pos = 6'(PTE_WR_BASE) + 6'(mode);
        grant  = {pte[rd_pos], pte[wr_pos], pte[rd_pos]};
        keep   = grant & ~pte[PTE_FO_BASE +: 3];
        perm   = keep;
    end

    // Access violation first, then fault-on in exec/write/read order.
    always_comb begin
        fault = FLT_NONE;
        if (need != 3'b000 && (grant & need) == 3'b000) begin
            fault = FLT_ACCESS;
        end else if (need != 3'b000 && (keep & need) == 3'b000) begin
            if (need[ACC_EX])      fault = FLT_ON_EXEC;
            else if (need[ACC_WR]) fault = FLT_ON_WRITE;
            else                   fault = FLT_ON_READ;
        end
    end
endmodule

// File: rtl/vaw_top.sv
// Three-level page table walker. Accepts one request at a time; superpage
// and malformed addresses finish in one cycle, others walk through a single
// read port with one outstanding read. Results hold until the next strobe.
// Assumes ptbr is stable at acceptance and memory answers each read once.
module vaw_top
    import vaw_pkg::*;
#(
    parameter int VA_BITS   = 44,
    parameter int PAGE_BITS = 13,
    parameter int IDX_BITS  = 10,
    parameter int LEVELS    = 3,
    parameter int MODE_BITS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [63:0]          req_va,
    input  logic [MODE_BITS-1:0] req_mode,
    input  logic [2:0]           req_need,
    input  logic [63:0]          ptbr,
    output logic                 mem_req_valid,
    input  logic                 mem_req_ready,
    output logic [63:0]          mem_req_addr,
    input  logic                 mem_rsp_valid,
    input  logic [63:0]          mem_rsp_data,
    output logic                 done,
    output logic [2:0]           fault,
    output logic [63:0]          pa_page,
    output logic [2:0]           perm
);
    localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1;
    localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);

    vaw_state_e           state_q, state_d;
    logic [LVL_W-1:0]     lvl_q;
    logic [63:0]          va_q;
    logic [MODE_BITS-1:0] mode_q;
    logic [2:0]           need_q;
    logic [63:0]          tbase_q;
    logic                 done_q;
    vaw_fault_e           fault_q;
    logic [63:0]          pa_q;
    logic [2:0]           perm_q;

    logic                 addr_ok, is_super;
    logic [63:0]          super_pa, entry_addr, next_base;
    logic [2:0]           leaf_perm;
    vaw_fault_e           leaf_fault;

    logic                 take, descend, fin;
    vaw_fault_e           fin_fault;
    logic [63:0]          fin_pa;
    logic [2:0]           fin_perm;

    vaw_classify #(
        .VA_BITS   (VA_BITS),
        .PAGE_BITS (PAGE_BITS)
    ) u_classify (
        .va       (req_va),
        .addr_ok  (addr_ok),
        .is_super (is_super),
        .super_pa (super_pa)
    );

    vaw_index_sel #(
        .PAGE_BITS (PAGE_BITS),
        .IDX_BITS  (IDX_BITS),
        .LEVELS    (LEVELS),
        .LVL_W     (LVL_W)
    ) u_index (
        .va         (va_q),
        .lvl        (lvl_q),
        .tbase      (tbase_q),
        .entry_addr (entry_addr)
    );

    vaw_leaf_perm #(
        .MODE_BITS (MODE_BITS)
    ) u_leaf (
        .pte   (mem_rsp_data),
        .mode  (mode_q),
        .need  (need_q),
        .perm  (leaf_perm),
        .fault (leaf_fault)
    );

    // Next table or final page address from the fetched entry.
    always_comb begin
        next_base = 64'(mem_rsp_data[63:PTE_PFN_LSB]) << PAGE_BITS;
    end

    // Walk control: decide acceptance, descent and completion each cycle.
    always_comb begin
        state_d   = state_q;
        take      = 1'b0;
        descend   = 1'b0;
        fin       = 1'b0;
        fin_fault = FLT_NONE;
        fin_pa    = '0;
        fin_perm  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    take = 1'b1;
                    if (!addr_ok) begin
                        fin       = 1'b1;
                        fin_fault = FLT_ACCESS;
                    end else if (is_super) begin
                        fin = 1'b1;
                        if (req_mode == '0) begin
                            fin_pa   = super_pa;
                            fin_perm = 3'b111;
                        end else begin
                            fin_fault = FLT_ACCESS;
                        end
                    end else begin
                        state_d = ST_ISSUE;
                    end
                end
            end
            ST_ISSUE: begin
                if (mem_req_ready) state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    if (!mem_rsp_data[PTE_VALID_BIT]) begin
                        fin       = 1'b1;
                        fin_fault = FLT_INVALID;
                        state_d   = ST_IDLE;
                    end else if (lvl_q != LAST_LVL) begin
                        if (!mem_rsp_data[PTE_RD_BASE]) begin
                            fin       = 1'b1;
                            fin_fault = FLT_ACCESS;
                            state_d   = ST_IDLE;
                        end else begin
                            descend = 1'b1;
                            state_d = ST_ISSUE;
                        end
                    end else begin
                        fin       = 1'b1;
                        fin_fault = leaf_fault;
                        state_d   = ST_IDLE;
                        if (leaf_fault == FLT_NONE) begin
                            fin_pa   = next_base;
                            fin_perm = leaf_perm;
                        end
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Register walk context, results and the completion strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            lvl_q   <= '0;
            va_q    <= '0;
            mode_q  <= '0;
            need_q  <= '0;
            tbase_q <= '0;
            done_q  <= 1'b0;
            fault_q <= FLT_NONE;
            pa_q    <= '0;
            perm_q  <= '0;
        end else begin
            state_q <= state_d;
            done_q  <= fin;
            if (take) begin
                va_q    <= req_va;
                mode_q  <= req_mode;
                need_q  <= req_need;
                lvl_q   <= '0;
                tbase_q <= ptbr;
            end
            if (descend) begin
                tbase_q <= next_base;
                lvl_q   <= lvl_q + 1'b1;
            end
            if (fin) begin
                fault_q <= fin_fault;
                pa_q    <= fin_pa;
                perm_q  <= fin_perm;
            end
        end
    end

    // Drive ports from state and registered results.
    always_comb begin
        req_ready     = (state_q == ST_IDLE);
        mem_req_valid = (state_q == ST_ISSUE);
        mem_req_addr  = entry_addr;
        done          = done_q;
        fault         = fault_q;
        pa_page       = pa_q;
        perm          = perm_q;
    end
endmodule

// File: rtl/vaw_checker.sv
// Protocol and result checks for vaw_top, attached by bind below.
// Assumes memory responses follow accepted reads one beat at a time.
module vaw_checker #(
    parameter int PAGE_BITS = 13
) (
    input logic        clk,
    input logic        rst_n,
    input logic        req_ready,
    input logic        mem_req_valid,
    input logic        mem_req_ready,
    input logic [63:0] mem_req_addr,
    input logic        done,
    input logic [2:0]  fault,
    input logic [63:0] pa_page,
    input logic [2:0]  perm
);
    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    p_idle_no_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req_valid);

    p_entry_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> mem_req_addr[2:0] == 3'b000);

    p_fault_zeroes_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done && fault != 3'd0 |-> pa_page == 64'd0 && perm == 3'd0);

    p_result_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(pa_page) && $stable(fault) && $stable(perm));

    p_page_align_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> pa_page[PAGE_BITS-1:0] == '0);

    p_fault_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> fault <= 3'd5);
endmodule

bind vaw_top vaw_checker #(.PAGE_BITS(PAGE_BITS)) u_vaw_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_ready     (req_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .done          (done),
    .fault         (fault),
    .pa_page       (pa_page),
    .perm          (perm)
);

// File: tb/test_vaw_top.sv
// Bench for vaw_top: behavioural reference model plus a memory responder,
// outputs compared on every clock.
module test_vaw_top;
    localparam logic [63:0] PTBR = 64'h0000_0000_0010_0000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_ready;
    logic [63:0] req_va;
    logic [1:0]  req_mode;
    logic [2:0]  req_need;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic [63:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [63:0] mem_rsp_data;
    logic        done;
    logic [2:0]  fault;
    logic [63:0] pa_page;
    logic [2:0]  perm;

    int n_cmp = 0;
    int n_bad = 0;
    logic [63:0] mem [logic [63:0]];
    logic [63:0] exp_addr_q [$];

    always #5 clk = ~clk;

    vaw_top i_vaw_top (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_va(req_va), .req_mode(req_mode), .req_need(req_need), .ptbr(PTBR),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data),
        .done(done), .fault(fault), .pa_page(pa_page), .perm(perm)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] rd(input logic [63:0] a);
        return mem.exists(a) ? mem[a] : 64'd0;
    endfunction

    // Reference translation written from the requirements.
    function automatic void model(input logic [63:0] va, input logic [1:0] md,
                                  input logic [2:0] nd, output logic [2:0] f,
                                  output logic [63:0] pa, output logic [2:0] pm,
                                  output bit fast);
        logic [63:0] base, a, e;
        logic [2:0]  g, k;
        f = 3'd0; pa = 64'd0; pm = 3'd0; fast = 1'b1; e = 64'd0;
        if (!(va[63:43] == '0 || va[63:43] == '1)) begin f = 3'd2; return; end
        if (va[63] && va[42:41] == 2'b10) begin
            if (md != 2'd0) f = 3'd2;
            else begin
                pa = (va & 64'h0000_00FF_FFFF_FFFF) | (64'(va[40]) << 43);
                pa[12:0] = '0;
                pm = 3'b111;
            end
            return;
        end
        fast = 1'b0;
        base = PTBR;
        for (int l = 0; l < 3; l++) begin
            a = base + (((va >> (13 + 10 * (2 - l))) & 64'd1023) * 8);
            exp_addr_q.push_back(a);
            e = rd(a);
            if (!e[0]) begin f = 3'd1; return; end
            if (l < 2) begin
                if (!e[8]) begin f = 3'd2; return; end
                base = (e >> 32) << 13;
            end
        end
        g = {e[8 + md], e[12 + md], e[8 + md]};
        if (nd != 3'd0 && (g & nd) == 3'd0) begin f = 3'd2; return; end
        k = g & ~e[3:1];
        if (nd != 3'd0 && (k & nd) == 3'd0) begin
            f = nd[2] ? 3'd5 : (nd[1] ? 3'd4 : 3'd3);
            return;
        end
        pa = (e >> 32) << 13;
        pm = k;
    endfunction

    function automatic logic [63:0] mkva(input int i1, input int i2, input int i3);
        return (64'(i1) << 33) | (64'(i2) << 23) | (64'(i3) << 13) | 64'h5A5;
    endfunction

    // Memory responder: varying ready and latency, single-beat answers.
    initial begin
        int tick = 0;
        int cd = -1;
        logic [63:0] pend = 64'd0;
        logic rdy;
        mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = 64'd0;
        forever begin
            @(negedge clk);
            tick++;
            mem_rsp_valid = 1'b0;
            if (cd == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = rd(pend);
                cd = -1;
            end else if (cd > 0) begin
                cd--;
            end
            rdy = (tick % 4 != 2) && (cd < 0) && !mem_rsp_valid;
            mem_req_ready = rdy;
            if (rst_n && rdy && mem_req_valid) begin
                pend = mem_req_addr;
                cd = tick % 3;
                if (exp_addr_q.size() == 0)
                    chk(1'b0, "R4 unexpected entry read", mem_req_addr, 64'd0);
                else
                    chk(mem_req_addr == exp_addr_q[0], "R4 entry address", mem_req_addr, exp_addr_q[0]);
                if (exp_addr_q.size() != 0) void'(exp_addr_q.pop_front());
            end
        end
    end

    // Per-clock comparison: results held between strobes, no read while ready.
    initial begin
        logic [63:0] h_pa = 64'd0;
        logic [2:0]  h_f = 3'd0, h_pm = 3'd0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                chk(!(req_ready && mem_req_valid), "R10 read while idle", 64'(mem_req_valid), 64'd0);
                if (done) begin
                    h_pa = pa_page; h_f = fault; h_pm = perm;
                end else begin
                    chk(pa_page == h_pa && fault == h_f && perm == h_pm,
                        "R11 results held", pa_page, h_pa);
                end
            end
        end
    end

    task automatic run(input logic [63:0] va, input logic [1:0] md, input logic [2:0] nd, input string tag);
        logic [2:0]  ef, ep;
        logic [63:0] ea;
        bit          fast;
        int          waited;
        model(va, md, nd, ef, ea, ep, fast);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_va = va; req_mode = md; req_need = nd;
        @(negedge clk);
        req_valid = 1'b0;
        if (fast) begin
            chk(done === 1'b1, {tag, " done one cycle after accept"}, 64'(done), 64'd1);
        end else begin
            waited = 0;
            while (done !== 1'b1 && waited < 300) begin @(negedge clk); waited++; end
            chk(done === 1'b1, {tag, " walk completes"}, 64'(done), 64'd1);
        end
        chk(fault == ef, {tag, " fault"}, 64'(fault), 64'(ef));
        chk(pa_page == ea, {tag, " page"}, pa_page, ea);
        chk(perm == ep, {tag, " perm"}, 64'(perm), 64'(ep));
        chk(exp_addr_q.size() == 0, {tag, " read count"}, 64'(exp_addr_q.size()), 64'd0);
        @(negedge clk);
        chk(done === 1'b0, "R11 strobe one cycle", 64'(done), 64'd0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(100000 * 10);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        req_valid = 1'b0; req_va = 64'd0; req_mode = 2'd0; req_need = 3'd0;
        rst_n = 1'b0;
        mem[PTBR + 1*8]                  = {32'h0000_0200, 32'h0000_0101};
        mem[PTBR + 3*8]                  = {32'h0000_0210, 32'h0000_0001};
        mem[(64'h200 << 13) + 2*8]       = {32'h0000_0300, 32'h0000_0101};
        mem[(64'h200 << 13) + 5*8]       = {32'h0000_0400, 32'h0000_0001};
        mem[(64'h300 << 13) + 3*8]       = {32'h000A_BCDE, 32'h0000_FF01};
        mem[(64'h300 << 13) + 4*8]       = {32'h0000_1111, 32'h0000_0101};
        mem[(64'h300 << 13) + 5*8]       = {32'h0000_2222, 32'h0000_110F};
        mem[(64'h300 << 13) + 7*8]       = {32'h0000_3333, 32'h0000_1105};
        mem[(64'h300 << 13) + 8*8]       = {32'h0000_4444, 32'h0000_8801};
        mem[(64'h300 << 13) + 9*8]       = {32'h0000_5555, 32'h0000_2201};
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done == 1'b0 && req_ready == 1'b1 && fault == 3'd0 && pa_page == 64'd0 && perm == 3'd0,
            "R11 reset state", {pa_page[59:0], 1'b0, fault}, 64'd0);

        run(mkva(1, 2, 3), 2'd0, 3'b001, "R4 kernel read");
        run(mkva(1, 2, 3), 2'd1, 3'b110, "R7 mode1 write exec");
        run(mkva(1, 2, 4), 2'd0, 3'b010, "R7 write not granted");
        run(mkva(1, 2, 4), 2'd3, 3'b001, "R7 user read not granted");
        run(mkva(1, 2, 9), 2'd1, 3'b010, "R7 shifted enable grants");
        run(mkva(1, 2, 9), 2'd0, 3'b001, "R7 kernel bit clear");
        run(mkva(1, 2, 8), 2'd3, 3'b011, "R7 user read write");
        run(mkva(1, 2, 5), 2'd0, 3'b001, "R9 fault on read");
        run(mkva(1, 2, 5), 2'd0, 3'b111, "R9 exec first");
        run(mkva(1, 2, 5), 2'd0, 3'b011, "R9 write before read");
        run(mkva(1, 2, 7), 2'd0, 3'b001, "R8 write removed");
        run(mkva(1, 2, 7), 2'd0, 3'b010, "R8 fault on write");
        run(mkva(1, 2, 7), 2'd0, 3'b000, "R12 probe");
        run(mkva(1, 2, 5), 2'd0, 3'b000, "R12 probe all removed");
        run(mkva(1, 2, 6), 2'd0, 3'b001, "R5 leaf not valid");
        run(mkva(2, 0, 0), 2'd0, 3'b001, "R5 level1 not valid");
        run(mkva(3, 0, 0), 2'd0, 3'b001, "R6 level1 no read enable");
        run(mkva(1, 5, 0), 2'd0, 3'b001, "R6 level2 no read enable");
        run(64'h0000_1000_0000_0000, 2'd0, 3'b001, "R1 bad extension");
        run(64'h8000_0000_0000_0000, 2'd0, 3'b001, "R1 bad negative extension");
        run(64'hFFFF_F800_0000_0000, 2'd0, 3'b001, "R1 good negative walk");
        run(64'h0000_0400_0000_0000, 2'd0, 3'b001, "R2 positive segment walks");
        run(64'hFFFF_FD12_3456_789A, 2'd0, 3'b010, "R3 superpage bit 40 set");
        run(64'hFFFF_FC00_0ABC_DEF0, 2'd0, 3'b100, "R3 superpage bit 40 clear");
        run(64'hFFFF_FD12_3456_789A, 2'd3, 3'b001, "R2 superpage user");
        run(64'hFFFF_FC00_0000_0000, 2'd1, 3'b000, "R2 superpage mode1");
        run(mkva(1, 2, 3), 2'd3, 3'b100, "R10 back to back walk");

        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule